// File: doc/BRIEF.md
# Descriptor Ring Pointer Unit

This block keeps the two descriptor pointers of an Ethernet MAC's DMA engine, one for transmit and one for receive. Each pointer walks a circular ring of descriptors in memory. The ring has no fixed length. The DMA logic pulses an advance strobe for a ring when it has finished with a descriptor, and it supplies that descriptor's end-of-ring flag with the strobe. If the flag is set, the pointer returns to the ring's base address. If it is clear, the pointer moves forward by the ring's descriptor stride.

The block also holds the DMA burst-length and arbitration control word. Two 4-bit fields in this word set the descriptor strides, in units of 8 bytes. The block refuses any control write that would make either stride smaller than a basic 16-byte descriptor, and it records the refusal in a sticky error flag. The remaining fields of the word (burst sizes and inter-frame-gap settings) are only stored. They are brought out decoded for other logic and for read-back.

Top module: `ring_ptr_unit`

## Requirements
- R1: After reset, the control word reads 0x00022000, both pointers and both base addresses are 0, and the error flag is 0.
- R2: The receive stride in bytes is bits 15:12 of the control word times 8. An rx advance with the end-of-ring flag clear adds that stride to the receive pointer.
- R3: The transmit stride in bytes is bits 19:16 of the control word times 8. A tx advance with the end-of-ring flag clear adds that stride to the transmit pointer.
- R4: An advance with the end-of-ring flag set loads the ring's base address into its pointer.
- R5: A control write is dropped when bits 19:16 or bits 15:12 of the write data are below 2. The old word is kept, and the error flag is set in the next cycle.
- R6: The error flag stays set until a clear pulse arrives with no rejected write in the same cycle. If a rejected write and a clear pulse arrive together, the flag ends up set.
- R7: Bits 23:8 of an accepted write are stored, and all other bits read as 0. Bits 9:8 are output as the rx burst size, bits 11:10 as the tx burst size, bits 22:20 as the gap count, and bit 23 as the gap-increment enable.
- R8: A base write whose address has bits 2:0 equal to zero stores the base and loads the ring's pointer in the same step. A base write with any of bits 2:0 set is ignored.
- R9: A stride change alters neither pointer when it is written. It is first used by the next advance of each ring.
- R10: Tx and rx advances in the same cycle each update their own pointer, and the new address is visible one cycle after the strobe.
- R11: If a base write and an advance reach the same ring in one cycle, the base write wins.
- R12: A pointer keeps its value in any cycle with no advance and no accepted base write for its ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control-word write strobe |
| cfg_wdata | input | 32 | Control-word write data |
| cfg_rdata | output | 32 | Stored control word |
| err_clr | input | 1 | Clear pulse for the error flag |
| cfg_err | output | 1 | Sticky flag for a rejected control write |
| tx_base_wr | input | 1 | Transmit ring base write strobe |
| rx_base_wr | input | 1 | Receive ring base write strobe |
| base_wdata | input | AW | Base address write data |
| tx_adv | input | 1 | Transmit descriptor finished |
| tx_eor | input | 1 | End-of-ring flag of that transmit descriptor |
| rx_adv | input | 1 | Receive descriptor finished |
| rx_eor | input | 1 | End-of-ring flag of that receive descriptor |
| tx_addr | output | AW | Current transmit descriptor address |
| rx_addr | output | AW | Current receive descriptor address |
| rx_burst | output | 2 | Stored rx burst size |
| tx_burst | output | 2 | Stored tx burst size |
| ifg_cnt | output | 3 | Stored inter-frame-gap count |
| ifg_inc | output | 1 | Stored gap-increment enable |

## Verification
The assertions expect that every input is at a known value at each clock edge after reset. They also expect that the pointer arithmetic may wrap modulo 2^AW without that counting as an error. The bench changes inputs only just after a rising edge. It writes base addresses far from the top of the address space, so the advances it applies never approach a wrap. The end-of-ring flags are driven only in cycles where they matter, but the block ignores them whenever the matching advance strobe is low.

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit #(
  parameter int AW = 32,
  parameter logic [31:0] CTRL_RST = 32'h0002_2000,
  parameter logic [31:0] CTRL_MASK = 32'h00FF_FF00,
  parameter int MIN_UNITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          err_clr,
  output logic          cfg_err,
  input  logic          tx_base_wr,
  input  logic          rx_base_wr,
  input  logic [AW-1:0] base_wdata,
  input  logic          tx_adv,
  input  logic          tx_eor,
  input  logic          rx_adv,
  input  logic          rx_eor,
  output logic [AW-1:0] tx_addr,
  output logic [AW-1:0] rx_addr,
  output logic [1:0]    rx_burst,
  output logic [1:0]    tx_burst,
  output logic [2:0]    ifg_cnt,
  output logic          ifg_inc
);
  localparam int ALIGN = 3;

  logic [31:0]   ctrl;
  logic [AW-1:0] tx_base, rx_base;
  logic [AW-1:0] tx_stride, rx_stride;
  logic          wr_ok, wr_bad, base_ok;

  assign wr_ok   = (cfg_wdata[19:16] >= 4'(MIN_UNITS)) && (cfg_wdata[15:12] >= 4'(MIN_UNITS));
  assign wr_bad  = cfg_wr && !wr_ok;
  assign base_ok = (base_wdata[ALIGN-1:0] == '0);

  assign tx_stride = AW'({ctrl[19:16], 3'b000});
  assign rx_stride = AW'({ctrl[15:12], 3'b000});

  assign cfg_rdata = ctrl;
  assign rx_burst  = ctrl[9:8];
  assign tx_burst  = ctrl[11:10];
  assign ifg_cnt   = ctrl[22:20];
  assign ifg_inc   = ctrl[23];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RST & CTRL_MASK;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_wr && wr_ok) ctrl <= cfg_wdata & CTRL_MASK;
      if (wr_bad)          cfg_err <= 1'b1;
      else if (err_clr)    cfg_err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_base <= '0;
      tx_addr <= '0;
    end else if (tx_base_wr && base_ok) begin
      tx_base <= base_wdata;
      tx_addr <= base_wdata;
    end else if (tx_adv) begin
      tx_addr <= tx_eor ? tx_base : tx_addr + tx_stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_base <= '0;
      rx_addr <= '0;
    end else if (rx_base_wr && base_ok) begin
      rx_base <= base_wdata;
      rx_addr <= base_wdata;
    end else if (rx_adv) begin
      rx_addr <= rx_eor ? rx_base : rx_addr + rx_stride;
    end
  end

  AST_CTRL_MIN_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[19:16] >= 4'(MIN_UNITS)) && (cfg_rdata[15:12] >= 4'(MIN_UNITS))); // R5
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> ($stable(cfg_rdata) && cfg_err)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !err_clr) |=> cfg_err); // R6
  AST_TX_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_addr[ALIGN-1:0] == '0); // R8
  AST_RX_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_addr[ALIGN-1:0] == '0); // R8
  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_adv && !tx_eor && !tx_base_wr) |=> tx_addr == $past(tx_addr) + $past(tx_stride)); // R3
  AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_adv && !rx_eor && !rx_base_wr) |=> rx_addr == $past(rx_addr) + $past(rx_stride)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_adv && !tx_base_wr) |=> $stable(tx_addr)); // R12
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_adv && !rx_base_wr) |=> $stable(rx_addr)); // R12
endmodule

// File: tb/test_ring_ptr_unit.sv
module test_ring_ptr_unit;
  localparam int AW = 32;

  // each entry: {expected error flag, write data, expected read-back}
  localparam logic [64:0] VEC [7] = '{
    {1'b0, 32'h0004_4F97, 32'h0004_4F00},
    {1'b1, 32'h0001_1000, 32'h0004_4F00},
    {1'b1, 32'h0002_0000, 32'h0004_4F00},
    {1'b0, 32'hFFFF_FFFF, 32'h00FF_FF00},
    {1'b0, 32'h0002_2000, 32'h0002_2000},
    {1'b1, 32'h0003_1300, 32'h0002_2000},
    {1'b0, 32'h00A2_3200, 32'h00A2_3200}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, err_clr = 0, tx_base_wr = 0, rx_base_wr = 0;
  logic tx_adv = 0, tx_eor = 0, rx_adv = 0, rx_eor = 0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [AW-1:0] base_wdata = '0, tx_addr, rx_addr;
  logic cfg_err, ifg_inc;
  logic [1:0] rx_burst, tx_burst;
  logic [2:0] ifg_cnt;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ring_ptr_unit #(.AW(AW)) i_ring_ptr_unit (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5 rst_n = 1;
    tick;
    chk("R1 ctrl", cfg_rdata, 32'h0002_2000);
    chk("R1 tx", tx_addr, 0);
    chk("R1 rx", rx_addr, 0);
    chk("R1 err", cfg_err, 0);

    for (int i = 0; i < 7; i++) begin
      cfg_wdata = VEC[i][63:32]; cfg_wr = 1;
      tick;
      cfg_wr = 0;
      chk("R5/R7 readback", cfg_rdata, VEC[i][31:0]);
      chk("R5 err", cfg_err, VEC[i][64]);
      err_clr = 1;
      tick;
      err_clr = 0;
      chk("R6 clear", cfg_err, 0);
    end

    chk("R7 rx_burst", rx_burst, 2);
    chk("R7 tx_burst", tx_burst, 0);
    chk("R7 ifg_cnt", ifg_cnt, 2);
    chk("R7 ifg_inc", ifg_inc, 1);

    base_wdata = 32'h1000; tx_base_wr = 1; tick; tx_base_wr = 0;
    chk("R8 tx base", tx_addr, 32'h1000);
    base_wdata = 32'h2000; rx_base_wr = 1; tick; rx_base_wr = 0;
    chk("R8 rx base", rx_addr, 32'h2000);
    base_wdata = 32'h3004; tx_base_wr = 1; tick; tx_base_wr = 0;
    chk("R8 misaligned", tx_addr, 32'h1000);

    tx_adv = 1; rx_adv = 1; tick; tx_adv = 0; rx_adv = 0;
    chk("R3 R10 tx step 16", tx_addr, 32'h1010);
    chk("R2 R10 rx step 24", rx_addr, 32'h2018);
    tick;
    chk("R12 tx hold", tx_addr, 32'h1010);
    chk("R12 rx hold", rx_addr, 32'h2018);

    cfg_wdata = 32'h0004_4F97; cfg_wr = 1; tick; cfg_wr = 0;
    chk("R9 tx not adjusted", tx_addr, 32'h1010);
    chk("R9 rx not adjusted", rx_addr, 32'h2018);
    tx_adv = 1; rx_adv = 1; tick; tx_adv = 0; rx_adv = 0;
    chk("R9 tx new stride", tx_addr, 32'h1030);
    chk("R9 rx new stride", rx_addr, 32'h2038);

    tx_adv = 1; tx_eor = 1; tick; tx_adv = 0; tx_eor = 0;
    chk("R4 R8 tx wrap to kept base", tx_addr, 32'h1000);
    chk("R10 rx untouched", rx_addr, 32'h2038);
    rx_adv = 1; rx_eor = 1; tick; rx_adv = 0; rx_eor = 0;
    chk("R4 rx wrap", rx_addr, 32'h2000);

    cfg_wdata = 32'h0000_0000; cfg_wr = 1; err_clr = 1; tick; cfg_wr = 0; err_clr = 0;
    chk("R6 set wins", cfg_err, 1);
    chk("R5 kept", cfg_rdata, 32'h0004_4F00);
    tick;
    chk("R6 sticky", cfg_err, 1);
    err_clr = 1; tick; err_clr = 0;
    chk("R6 cleared", cfg_err, 0);

    base_wdata = 32'h4000; tx_base_wr = 1; tx_adv = 1; tick; tx_base_wr = 0; tx_adv = 0;
    chk("R11 base wins", tx_addr, 32'h4000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule